// File: doc/BRIEF.md
# Clock-Signaling Mode Transition Controller

This block sequences changes of the signaling style of three memory-interface timing signals: the command clock, the write clock and the read strobe. The command clock and the write clock each run either differential or single-ended. The read strobe runs differential, single-ended, or is switched off, in which case reads are captured with a strobe generated inside the host. A request carries the wanted style of all three signals, the active polarity of the write clock and of the read strobe, and the current data rate. The block checks the request against the cross-signal rules and the data-rate ceiling. It rejects an illegal request with a one-cycle error pulse and leaves everything as it was.

A legal request is carried out as a fixed sequence of handshakes. The termination handshake covers six signal groups together: command clock, write clock, read strobe, command/address, data and data-mask-inversion. The mode handshake applies the new signaling styles. When the target uses any non-differential signal, termination is switched off before the styles change. When the target is all-differential, the styles change first and termination is switched back on afterwards. A one-cycle done pulse closes the sequence. While a sequence runs the block is busy, and it drops any new request without queuing it.

Top module: `sig_mode_ctrl`

## Requirements
- R1: After reset all three signals are differential, both polarities are 0, all six termination enables are 1, the internal capture strobe is off, and busy, err, done, term_req and mode_req are 0.
- R2: A target in which any signal is non-differential is legal only when rate_mbps is at most 1600. At 1601 or above such a request is rejected. An all-differential target is accepted at any rate.
- R3: A single-ended write clock, or a single-ended read strobe, is legal only together with a single-ended command clock.
- R4: Read-strobe codes are 00 differential, 01 single-ended, 10 off and 11 reserved (always illegal). A single-ended write clock requires the read strobe to be off, or single-ended with rs polarity equal to wck polarity. Strobe off requires both clocks to be single-ended. int_strobe_en is 1 exactly when the applied read strobe is off.
- R5: A single-ended command clock with a differential write clock and a differential read strobe is legal at or below the rate ceiling.
- R6: An illegal request accepted while idle raises err for exactly one cycle, in the cycle after the request. It starts no handshake and leaves the applied modes and the termination enables unchanged.
- R7: For a target with any non-differential signal, the first handshake is term_req with term_set=0. On its acknowledge all term_en bits become 0. Only after that is mode_req raised, with tgt_* equal to the request. The applied modes take the target values on mode_ack.
- R8: For an all-differential target, mode_req comes first and the applied modes change on its acknowledge. Then term_req with term_set=1 follows, and all term_en bits become 1 on its acknowledge.
- R9: Each handshake request stays high until its acknowledge is sampled. busy is 1 from the cycle after an accepted legal request until the final acknowledge. done pulses for one cycle after the final acknowledge, with busy already 0.
- R10: A request presented while busy is dropped. It raises no err, does not change tgt_*, and the running sequence ends with the originally requested modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode change request strobe |
| req_ck_se | input | 1 | Requested command clock: 1 single-ended, 0 differential |
| req_wck_se | input | 1 | Requested write clock: 1 single-ended, 0 differential |
| req_rs_mode | input | 2 | Requested read strobe: 00 diff, 01 single-ended, 10 off, 11 reserved |
| req_wck_pol | input | 1 | Requested write clock active polarity |
| req_rs_pol | input | 1 | Requested read strobe active polarity |
| rate_mbps | input | RATE_W | Current data rate in Mbps |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle illegal-request pulse |
| done | output | 1 | One-cycle completion pulse |
| term_req | output | 1 | Termination change request |
| term_set | output | 1 | Requested termination state: 1 on, 0 off |
| term_ack | input | 1 | Termination change acknowledge |
| term_en | output | NGRP | Applied termination enables, one per signal group |
| mode_req | output | 1 | Signaling mode change request |
| mode_ack | input | 1 | Signaling mode change acknowledge |
| tgt_ck_se | output | 1 | Target command clock style |
| tgt_wck_se | output | 1 | Target write clock style |
| tgt_rs_mode | output | 2 | Target read strobe mode |
| tgt_wck_pol | output | 1 | Target write clock polarity |
| tgt_rs_pol | output | 1 | Target read strobe polarity |
| ck_se | output | 1 | Applied command clock style |
| wck_se | output | 1 | Applied write clock style |
| rs_mode | output | 2 | Applied read strobe mode |
| wck_pol | output | 1 | Applied write clock polarity |
| rs_pol | output | 1 | Applied read strobe polarity |
| int_strobe_en | output | 1 | Internal read capture strobe enable |

## Verification
The bench targets the rate boundary at 1600 and 1601 Mbps. It also covers the polarity match between a single-ended write clock and read strobe, the reserved strobe code, strobe-off with a differential write clock, and the legal single-ended command clock with both other signals differential. A design with an off-by-one rate compare, or a missing cross-signal rule, would apply a forbidden mode instead of pulsing err. The bench watches the order of the two handshakes in both directions. A controller that switched styles with termination still on, or that re-enabled termination before returning to differential, would show the wrong first request. Requests injected mid-sequence check that a busy controller neither flags nor retargets.

// File: rtl/sig_mode_ctrl.sv
module sig_mode_ctrl #(
  parameter int RATE_W      = 14,
  parameter int SE_MAX_RATE = 1600,
  parameter int NGRP        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ck_se,
  input  logic              req_wck_se,
  input  logic [1:0]        req_rs_mode,
  input  logic              req_wck_pol,
  input  logic              req_rs_pol,
  input  logic [RATE_W-1:0] rate_mbps,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic              term_req,
  output logic              term_set,
  input  logic              term_ack,
  output logic [NGRP-1:0]   term_en,
  output logic              mode_req,
  input  logic              mode_ack,
  output logic              tgt_ck_se,
  output logic              tgt_wck_se,
  output logic [1:0]        tgt_rs_mode,
  output logic              tgt_wck_pol,
  output logic              tgt_rs_pol,
  output logic              ck_se,
  output logic              wck_se,
  output logic [1:0]        rs_mode,
  output logic              wck_pol,
  output logic              rs_pol,
  output logic              int_strobe_en
);
  localparam logic [1:0] RS_DIFF = 2'b00;
  localparam logic [1:0] RS_SE   = 2'b01;
  localparam logic [1:0] RS_OFF  = 2'b10;
  localparam logic [1:0] RS_RSV  = 2'b11;
  localparam logic [RATE_W-1:0] RATE_CAP = RATE_W'(SE_MAX_RATE);

  typedef enum logic [2:0] {S_IDLE, S_TOFF, S_MDN, S_MUP, S_TON} st_t;
  st_t st;

  logic req_low, rate_ok, ck_dep_ok, wck_dep_ok, off_dep_ok, req_ok, tgt_low;

  assign req_low    = req_ck_se | req_wck_se | (req_rs_mode != RS_DIFF);
  assign rate_ok    = !req_low || (rate_mbps <= RATE_CAP);
  assign ck_dep_ok  = !(req_wck_se || req_rs_mode == RS_SE) || req_ck_se;
  assign wck_dep_ok = !req_wck_se || req_rs_mode == RS_OFF ||
                      (req_rs_mode == RS_SE && req_rs_pol == req_wck_pol);
  assign off_dep_ok = (req_rs_mode != RS_OFF) || (req_ck_se && req_wck_se);
  assign req_ok     = (req_rs_mode != RS_RSV) && rate_ok && ck_dep_ok &&
                      wck_dep_ok && off_dep_ok;

  assign tgt_low  = tgt_ck_se | tgt_wck_se | (tgt_rs_mode != RS_DIFF);
  assign busy     = (st != S_IDLE);
  assign term_req = (st == S_TOFF) || (st == S_TON);
  assign term_set = (st == S_TON);
  assign mode_req = (st == S_MDN) || (st == S_MUP);
  assign int_strobe_en = (rs_mode == RS_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      err         <= 1'b0;
      done        <= 1'b0;
      term_en     <= '1;
      tgt_ck_se   <= 1'b0;
      tgt_wck_se  <= 1'b0;
      tgt_rs_mode <= RS_DIFF;
      tgt_wck_pol <= 1'b0;
      tgt_rs_pol  <= 1'b0;
      ck_se       <= 1'b0;
      wck_se      <= 1'b0;
      rs_mode     <= RS_DIFF;
      wck_pol     <= 1'b0;
      rs_pol      <= 1'b0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_ok) begin
            tgt_ck_se   <= req_ck_se;
            tgt_wck_se  <= req_wck_se;
            tgt_rs_mode <= req_rs_mode;
            tgt_wck_pol <= req_wck_pol;
            tgt_rs_pol  <= req_rs_pol;
            st          <= req_low ? S_TOFF : S_MUP;
          end else begin
            err <= 1'b1;
          end
        end
        S_TOFF: if (term_ack) begin
          term_en <= '0;
          st      <= S_MDN;
        end
        S_MDN, S_MUP: if (mode_ack) begin
          ck_se   <= tgt_ck_se;
          wck_se  <= tgt_wck_se;
          rs_mode <= tgt_rs_mode;
          wck_pol <= tgt_wck_pol;
          rs_pol  <= tgt_rs_pol;
          if (st == S_MUP) begin
            st <= S_TON;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_TON: if (term_ack) begin
          term_en <= '1;
          st      <= S_IDLE;
          done    <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  term_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && tgt_low) |-> (term_en == '0));
  // R8
  term_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req && term_set) |-> (!ck_se && !wck_se && rs_mode == RS_DIFF));
  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R6
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !mode_ack) |=> mode_req);
  // R3
  ck_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wck_se || rs_mode == RS_SE) |-> ck_se);
  // R4
  wck_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wck_se |-> (rs_mode == RS_OFF || (rs_mode == RS_SE && rs_pol == wck_pol)));
  // R10
  busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({tgt_ck_se, tgt_wck_se, tgt_rs_mode, tgt_wck_pol, tgt_rs_pol}));
endmodule

// File: tb/tb_sig_mode_ctrl.sv
module tb_sig_mode_ctrl;
  localparam int RATE_W = 14;
  localparam int NGRP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ck_se = 1'b0, req_wck_se = 1'b0;
  logic [1:0] req_rs_mode = 2'b00;
  logic req_wck_pol = 1'b0, req_rs_pol = 1'b0;
  logic [RATE_W-1:0] rate_mbps = '0;
  logic term_ack = 1'b0, mode_ack = 1'b0;
  logic busy, err, done, term_req, term_set, mode_req;
  logic [NGRP-1:0] term_en;
  logic tgt_ck_se, tgt_wck_se, tgt_wck_pol, tgt_rs_pol;
  logic [1:0] tgt_rs_mode, rs_mode;
  logic ck_se, wck_se, wck_pol, rs_pol, int_strobe_en;

  always #2 clk = ~clk;

  sig_mode_ctrl #(.RATE_W(RATE_W), .SE_MAX_RATE(1600), .NGRP(NGRP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ck_se(req_ck_se),
    .req_wck_se(req_wck_se), .req_rs_mode(req_rs_mode), .req_wck_pol(req_wck_pol),
    .req_rs_pol(req_rs_pol), .rate_mbps(rate_mbps), .busy(busy), .err(err),
    .done(done), .term_req(term_req), .term_set(term_set), .term_ack(term_ack),
    .term_en(term_en), .mode_req(mode_req), .mode_ack(mode_ack),
    .tgt_ck_se(tgt_ck_se), .tgt_wck_se(tgt_wck_se), .tgt_rs_mode(tgt_rs_mode),
    .tgt_wck_pol(tgt_wck_pol), .tgt_rs_pol(tgt_rs_pol), .ck_se(ck_se),
    .wck_se(wck_se), .rs_mode(rs_mode), .wck_pol(wck_pol), .rs_pol(rs_pol),
    .int_strobe_en(int_strobe_en));

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_mode = 6'b0;
  logic [NGRP-1:0] m_term = '1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic bit is_low(input logic [5:0] m);
    return m[5] | m[4] | (m[3:2] != 2'b00);
  endfunction

  function automatic bit legal(input logic [5:0] m, input int rate);
    bit c = m[5], w = m[4], wp = m[1], rp = m[0];
    logic [1:0] r = m[3:2];
    if (r == 2'b11) return 0;
    if (is_low(m) && rate > 1600) return 0;
    if ((w || r == 2'b01) && !c) return 0;
    if (w && !(r == 2'b10 || (r == 2'b01 && wp == rp))) return 0;
    if (r == 2'b10 && !(c && w)) return 0;
    return 1;
  endfunction

  function automatic logic [5:0] cur_mode();
    return {ck_se, wck_se, rs_mode, wck_pol, rs_pol};
  endfunction

  function automatic logic [5:0] tgt_mode();
    return {tgt_ck_se, tgt_wck_se, tgt_rs_mode, tgt_wck_pol, tgt_rs_pol};
  endfunction

  task automatic drive(input logic [5:0] m, input int rate);
    {req_ck_se, req_wck_se, req_rs_mode, req_wck_pol, req_rs_pol} = m;
    rate_mbps = RATE_W'(rate);
  endtask

  task automatic ack_term(input int d);
    repeat (d) begin
      @(negedge clk);
      chk(term_req == 1'b1, "R9 term_req held", term_req, 1);
    end
    term_ack = 1'b1;
    @(negedge clk);
    term_ack = 1'b0;
  endtask

  task automatic ack_mode(input int d);
    repeat (d) begin
      @(negedge clk);
      chk(mode_req == 1'b1, "R9 mode_req held", mode_req, 1);
    end
    mode_ack = 1'b1;
    @(negedge clk);
    mode_ack = 1'b0;
  endtask

  task automatic run(input logic [5:0] m, input int rate, input bit inject, input string tag);
    bit ok = legal(m, rate);
    bit low = is_low(m);
    int d1 = $urandom_range(0, 3);
    int d2 = $urandom_range(0, 3);
    @(negedge clk);
    drive(m, rate);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk(err == 1'b1, {tag, " R6 err raised"}, err, 1);
      chk(!busy && !term_req && !mode_req, {tag, " R6 no handshake"},
          {busy, term_req, mode_req}, 0);
      @(negedge clk);
      chk(err == 1'b0, {tag, " R6 err one cycle"}, err, 0);
      chk(cur_mode() == m_mode && term_en == m_term, {tag, " R6 state kept"},
          {cur_mode(), term_en}, {m_mode, m_term});
      return;
    end
    chk(busy && !err, {tag, " R9 busy after accept"}, {busy, err}, 2);
    chk(tgt_mode() == m, {tag, " R7 target"}, tgt_mode(), m);
    if (inject) begin
      drive(~m, 6400);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!err && tgt_mode() == m, {tag, " R10 request dropped"}, {err, tgt_mode()}, {1'b0, m});
    end
    if (low) begin
      chk(term_req && !term_set && !mode_req, {tag, " R7 term off first"},
          {term_req, term_set, mode_req}, 4);
      ack_term(d1);
      chk(term_en == '0 && mode_req && !term_req, {tag, " R7 term off then mode"},
          {term_en, mode_req}, 1);
      chk(cur_mode() == m_mode, {tag, " R7 modes wait for ack"}, cur_mode(), m_mode);
      ack_mode(d2);
      m_term = '0;
    end else begin
      chk(mode_req && !term_req, {tag, " R8 mode first"}, {mode_req, term_req}, 2);
      ack_mode(d1);
      chk(cur_mode() == m && term_req && term_set, {tag, " R8 modes then term on"},
          {cur_mode(), term_req, term_set}, {m, 2'b11});
      ack_term(d2);
      m_term = '1;
    end
    m_mode = m;
    chk(done && !busy, {tag, " R9 done pulse"}, {done, busy}, 2);
    chk(cur_mode() == m && term_en == m_term, {tag, " R7 R8 final state"},
        {cur_mode(), term_en}, {m, m_term});
    chk(int_strobe_en == (m[3:2] == 2'b10), {tag, " R4 internal strobe"}, int_strobe_en,
        m[3:2] == 2'b10);
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4099));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_mode() == 6'b0 && term_en == '1 && !int_strobe_en, "R1 reset modes",
        {cur_mode(), term_en}, {6'b0, {NGRP{1'b1}}});
    chk(!busy && !err && !done && !term_req && !mode_req, "R1 reset outputs",
        {busy, err, done, term_req, mode_req}, 0);
    // R5 single-ended command clock only
    run(6'b100000, 1600, 0, "R5 ck only");
    // R2 rate boundary
    run(6'b110100, 1601, 0, "R2 above cap");
    run(6'b110100, 1600, 0, "R2 at cap");
    // R8 back to differential at top rate
    run(6'b000000, 6400, 1, "R8 return diff");
    // R3 write clock single-ended without command clock
    run(6'b010100, 800, 0, "R3 wck no ck");
    run(6'b000100, 800, 0, "R3 rs no ck");
    // R4 polarity mismatch, reserved, strobe off with diff wck
    run(6'b110110, 800, 0, "R4 pol mismatch");
    run(6'b111100, 800, 0, "R4 reserved");
    run(6'b101000, 800, 0, "R4 off diff wck");
    run(6'b111011, 800, 1, "R4 strobeless");
    run(6'b110111, 1200, 0, "R4 se both pol1");
    run(6'b000000, 3200, 0, "R8 diff again");
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom_range(0, 5);
      int rate = (sel == 0) ? 1600 : (sel == 1) ? 1601 : (sel == 2) ? 800 :
                 (sel == 3) ? 6400 : $urandom_range(100, 8000);
      run(6'($urandom), rate, ($urandom_range(0, 3) == 0), "R2 R3 R4 rand");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule